// File: doc/BRIEF.md
# Sequence-Serviced Watchdog Timer

This block is a watchdog for a system that must prove it is still alive. Software configures it through four 16-bit registers on a simple write bus with byte addressing. Once started, it counts down in half-second steps taken from a slow one-cycle tick enable. It reloads only when software writes a fixed pair of magic words to the service register, in the right order. If the count runs out, the block raises a reset request and records that the cause was a timeout.

Beside the main timer there are three more features. Software can ask for a reset at once by writing the control register. Software can make counting pause while a low-power input is high; this choice can be made only once after reset. A power-down counter starts at reset and sends one active-low pulse when it ends, unless software cancels it first.

Register map (byte offsets): control at 0x0, service at 0x2, cause/status at 0x4, power-down at 0x8. Control register fields: bits 15:8 hold the timeout value T; bit 4 is the soft-reset bit and is active low; bit 3 masks the reset output; bit 2 is run; bit 0 is the low-power pause. The soft-reset bit reads back as 1. Status register: bit 1 means a timeout happened, and bit 4 means no timeout has happened since power-on.

Top module: `svc_watchdog`

## Requirements
- R1: After power-on reset the registers read as follows: control 0x0010, status 0x0010, power-down 0x0001. The outputs are: wdogResetReq low, swResetReq low, pdnPulseN high.
- R2: Once running with timeout field T, the block expires on tick number T+1 after the last reload. Expiry sets status bit 1, clears status bit 4, and raises wdogResetReq. All of these stay set until power-on reset.
- R3: Writing 0x5555 and then 0xAAAA to the service register (offset 0x2) reloads the counter from the current timeout field. Writes to other registers between the two words do not break the pair.
- R4: Any other value written to the service register sends the tracker back to idle. A 0xAAAA that does not follow an armed 0x5555 does not reload.
- R5: Writing a new timeout field has no effect on the running count. The new value is used at the next reload.
- R6: Once the run bit (control bit 2) is set, software cannot clear it. The rising edge of run loads the counter from the field written in that same write.
- R7: The pause bit (control bit 0) takes its value from the first control write after reset; later writes leave it unchanged. While this bit is 1 and lowPowerIn is high, ticks do not change the count.
- R8: A control write with bit 4 at 0 raises swResetReq, which stays high until power-on reset. Writing it again has no further effect.
- R9: If power-down register bit 0 is still 1, then after PDN_TICKS ticks from reset pdnPulseN goes low for exactly one clock. Writing 0 to bit 0 before then stops the pulse. A later write of 1 does not turn the counter back on.
- R10: When control bit 3 is 1, expiry still updates the status register, but wdogResetReq stays low.
- R11: The status register is read-only: writing to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Power-on reset, active low |
| busWe | input | 1 | Write strobe, one cycle per write |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, combinational |
| tickEn | input | 1 | Slow tick enable, one clock wide, 2 Hz |
| lowPowerIn | input | 1 | Low-power state indication |
| wdogResetReq | output | 1 | Timeout reset request, sticky |
| swResetReq | output | 1 | Software reset request, sticky |
| pdnPulseN | output | 1 | Power-down end pulse, active low |

## Verification
The assertions assume three things about the inputs. First, tickEn is high for only one clock at a time. Second, each bus write lasts one cycle with a stable address. Third, every input changes only between clock edges. The stimulus drives every input on the falling edge or just after the rising edge, and it raises tickEn for exactly one clock per tick. Because of this, every count step and every reload can be traced to one sampled edge. The sticky and freeze properties depend on rstN being released only once per test segment, and each segment starts with a fresh power-on reset.

// File: rtl/svc_wdog_pkg.sv
package svc_wdog_pkg;

  localparam int DATA_W   = 16;
  localparam int TMO_W    = 8;

  localparam int OFS_CTRL = 'h0;
  localparam int OFS_SVC  = 'h2;
  localparam int OFS_STAT = 'h4;
  localparam int OFS_PDN  = 'h8;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 16'h5555;
  localparam logic [DATA_W-1:0] KEY_SECOND = 16'hAAAA;

  // Control register field positions
  localparam int BIT_PAUSE = 0;
  localparam int BIT_RUN   = 2;
  localparam int BIT_MASK  = 3;
  localparam int BIT_SWRN  = 4;
  localparam int TMO_LSB   = 8;

  typedef struct packed {
    logic             reload;
    logic             run;
    logic [TMO_W-1:0] loadVal;
    logic             pdnCancel;
  } dpCmd_t;

endpackage

// File: rtl/svc_wdog_ctrl.sv
module svc_wdog_ctrl
  import svc_wdog_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              lowPowerIn,
  input  logic              expired,
  output logic [DATA_W-1:0] busRdata,
  output dpCmd_t            cmd,
  output logic              swResetReq,
  output logic              resetMask
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_SVC  = ADDR_W'(OFS_SVC);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_PDN  = ADDR_W'(OFS_PDN);

  logic [TMO_W-1:0] tmoQ;
  logic             maskQ, runQ, pauseQ, pauseLockQ, swReqQ, pdnEnQ, armedQ;
  logic             wrCtrl, wrSvc, wrPdn;
  logic             runRise, svcReload;
  logic             unusedBits;

  assign wrCtrl = busWe && (busAddr == A_CTRL);
  assign wrSvc  = busWe && (busAddr == A_SVC);
  assign wrPdn  = busWe && (busAddr == A_PDN);

  assign runRise   = wrCtrl && !runQ && busWdata[BIT_RUN];
  assign svcReload = wrSvc && armedQ && (busWdata == KEY_SECOND);

  assign unusedBits = ^{busWdata[7:5], busWdata[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoQ       <= '0;
      maskQ      <= 1'b0;
      runQ       <= 1'b0;
      pauseQ     <= 1'b0;
      pauseLockQ <= 1'b0;
      swReqQ     <= 1'b0;
      pdnEnQ     <= 1'b1;
      armedQ     <= 1'b0;
    end else begin
      if (wrCtrl) begin
        tmoQ  <= busWdata[TMO_LSB +: TMO_W];
        maskQ <= busWdata[BIT_MASK];
        runQ  <= runQ | busWdata[BIT_RUN];
        if (!pauseLockQ) begin
          pauseQ     <= busWdata[BIT_PAUSE];
          pauseLockQ <= 1'b1;
        end
        if (!busWdata[BIT_SWRN]) swReqQ <= 1'b1;
      end
      if (wrSvc) armedQ <= (busWdata == KEY_FIRST);
      if (wrPdn && !busWdata[0]) pdnEnQ <= 1'b0;
    end
  end

  always_comb begin
    cmd.reload    = svcReload || runRise;
    cmd.loadVal   = runRise ? busWdata[TMO_LSB +: TMO_W] : tmoQ;
    cmd.run       = runQ && !(pauseQ && lowPowerIn);
    cmd.pdnCancel = wrPdn && !busWdata[0];
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_CTRL: busRdata = {tmoQ, 3'b000, 1'b1, maskQ, runQ, 1'b0, pauseQ};
      A_STAT: busRdata = {11'd0, ~expired, 2'b00, expired, 1'b0};
      A_PDN:  busRdata = {15'd0, pdnEnQ};
      default: busRdata = '0;
    endcase
  end

  assign swResetReq = swReqQ;
  assign resetMask  = maskQ;

  assert_run_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    runQ |=> runQ);

  assert_pause_locked_R7: assert property (@(posedge clk) disable iff (!rstN)
    pauseLockQ |=> $stable(pauseQ));

  assert_swreq_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    swReqQ |=> swReqQ);

  assert_pdn_no_reenable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !pdnEnQ |=> !pdnEnQ);

endmodule

// File: rtl/svc_wdog_dp.sv
module svc_wdog_dp
  import svc_wdog_pkg::*;
#(
  parameter int PDN_TICKS = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   tickEn,
  input  dpCmd_t cmd,
  output logic   expired,
  output logic   pdnPulseN
);

  localparam int PDN_W = $clog2(PDN_TICKS + 1);
  localparam logic [PDN_W-1:0] PDN_LAST = PDN_W'(PDN_TICKS - 1);

  logic [TMO_W-1:0] cntQ;
  logic             expiredQ;
  logic [PDN_W-1:0] pdnCntQ;
  logic             pdnActQ, pulseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ     <= '0;
      expiredQ <= 1'b0;
    end else if (cmd.reload) begin
      cntQ <= cmd.loadVal;
    end else if (tickEn && cmd.run && !expiredQ) begin
      if (cntQ == '0) expiredQ <= 1'b1;
      else            cntQ     <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdnCntQ <= '0;
      pdnActQ <= 1'b1;
      pulseQ  <= 1'b0;
    end else begin
      pulseQ <= 1'b0;
      if (cmd.pdnCancel) begin
        pdnActQ <= 1'b0;
      end else if (pdnActQ && tickEn) begin
        if (pdnCntQ == PDN_LAST) begin
          pulseQ  <= 1'b1;
          pdnActQ <= 1'b0;
        end else begin
          pdnCntQ <= pdnCntQ + 1'b1;
        end
      end
    end
  end

  assign expired   = expiredQ;
  assign pdnPulseN = !pulseQ;

  assert_expiry_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    expiredQ |=> expiredQ);

  assert_no_rise_without_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.reload |=> (cntQ <= $past(cntQ)));

  assert_frozen_when_halted_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.reload) |=> $stable(cntQ));

  assert_pulse_one_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |=> !pulseQ);

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svc_wdog_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PDN_TICKS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  input  logic              tickEn,
  input  logic              lowPowerIn,
  output logic              wdogResetReq,
  output logic              swResetReq,
  output logic              pdnPulseN
);

  dpCmd_t cmd;
  logic   expired, resetMask;

  svc_wdog_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .lowPowerIn(lowPowerIn), .expired(expired),
    .busRdata(busRdata), .cmd(cmd), .swResetReq(swResetReq),
    .resetMask(resetMask)
  );

  svc_wdog_dp #(.PDN_TICKS(PDN_TICKS)) uDp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cmd(cmd),
    .expired(expired), .pdnPulseN(pdnPulseN)
  );

  assign wdogResetReq = expired && !resetMask;

  assert_mask_blocks_request_R10: assert property (@(posedge clk) disable iff (!rstN)
    resetMask |-> !wdogResetReq);

endmodule

// File: tb/tb_svc_watchdog.sv
module tb_svc_watchdog;

  localparam int ADDR_W = 4;
  localparam int PDN_TICKS = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWe = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [15:0]       busWdata = '0;
  logic [15:0]       busRdata;
  logic              tickEn = 1'b0;
  logic              lowPowerIn = 1'b0;
  logic              wdogResetReq, swResetReq, pdnPulseN;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int pdnLowCount = 0;

  int    selQ[$];
  int    expQ[$];
  string tagQ[$];

  svc_watchdog #(.ADDR_W(ADDR_W), .PDN_TICKS(PDN_TICKS)) dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .tickEn(tickEn),
    .lowPowerIn(lowPowerIn), .wdogResetReq(wdogResetReq),
    .swResetReq(swResetReq), .pdnPulseN(pdnPulseN)
  );

  always #2 clk = ~clk;

  // Observation selectors
  localparam int OBS_RD = 0, OBS_WDR = 1, OBS_SWR = 2, OBS_PDN = 3;

  function automatic int observe(int sel);
    case (sel)
      OBS_RD:  return int'(busRdata);
      OBS_WDR: return int'(wdogResetReq);
      OBS_SWR: return int'(swResetReq);
      default: return int'(pdnPulseN);
    endcase
  endfunction

  // Monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin
    if (selQ.size() > 0) begin
      int sel, exp, act;
      string tag;
      sel = selQ.pop_front();
      exp = expQ.pop_front();
      tag = tagQ.pop_front();
      act = observe(sel);
      checks++;
      if (act != exp) begin
        fails++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
    end
    if (rstN && !pdnPulseN) pdnLowCount++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic expect_obs(int sel, int exp, string tag, int addr = 0);
    busAddr = ADDR_W'(addr);
    selQ.push_back(sel);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    wait (selQ.size() == 0);
  endtask

  task automatic expect_reg(int addr, int exp, string tag);
    expect_obs(OBS_RD, exp, tag, addr);
  endtask

  task automatic check_direct(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    busWe    = 1'b1;
    busAddr  = ADDR_W'(addr);
    busWdata = 16'(data);
    @(posedge clk);
    #1;
    busWe = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(posedge clk);
      #1;
      tickEn = 1'b0;
    end
  endtask

  task automatic do_reset();
    rstN = 1'b0;
    busWe = 1'b0;
    tickEn = 1'b0;
    lowPowerIn = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    pdnLowCount = 0;
  endtask

  initial begin
    // Segment A: reset state, power-down pulse, service sequences
    do_reset();
    expect_reg('h0, 'h0010, "R1 control reset value");
    expect_reg('h4, 'h0010, "R1 status reset value");
    expect_reg('h8, 'h0001, "R1 power-down reset value");
    expect_obs(OBS_WDR, 0, "R1 wdogResetReq low");
    expect_obs(OBS_SWR, 0, "R1 swResetReq low");
    expect_obs(OBS_PDN, 1, "R1 pdnPulseN high");

    ticks(PDN_TICKS - 1);
    check_direct(pdnLowCount, 0, "R9 no pulse before end");
    ticks(1);
    expect_obs(OBS_PDN, 0, "R9 pulse on final tick");
    expect_obs(OBS_PDN, 1, "R9 pulse lasts one clock");
    check_direct(pdnLowCount, 1, "R9 exactly one low cycle");

    wr('h0, 'h0314);                 // T=3, run
    ticks(3);
    expect_obs(OBS_WDR, 0, "R2 not yet expired");
    wr('h2, 'h5555);
    wr('h8, 'h0000);                 // other register between the keys
    wr('h2, 'hAAAA);
    ticks(3);
    expect_obs(OBS_WDR, 0, "R3 service reloaded counter");
    wr('h0, 'h0114);                 // T=1, pending
    wr('h2, 'hAAAA);                 // second key alone
    wr('h2, 'h5555);
    wr('h2, 'h1234);                 // wrong value disarms
    wr('h2, 'hAAAA);
    ticks(1);
    expect_obs(OBS_WDR, 1, "R4 wrong sequence did not reload");
    expect_reg('h4, 'h0002, "R2 status records timeout");

    // Segment B: field change deferred, run bit sticky
    do_reset();
    wr('h0, 'h0514);                 // T=5
    ticks(2);
    wr('h0, 'h0111);                 // T=1, clear run, set pause attempt
    expect_reg('h0, 'h0114, "R6 run bit held, pause locked");
    ticks(3);
    expect_obs(OBS_WDR, 0, "R5 new field not applied before reload");
    wr('h2, 'h5555);
    wr('h2, 'hAAAA);
    ticks(1);
    expect_obs(OBS_WDR, 0, "R5 reload uses new field, one tick left");
    ticks(1);
    expect_obs(OBS_WDR, 1, "R5 expiry after T+1 with new field");

    // Segment C: low-power pause
    do_reset();
    lowPowerIn = 1'b1;
    wr('h0, 'h0315);                 // T=3, run, pause
    ticks(10);
    expect_obs(OBS_WDR, 0, "R7 frozen while low power");
    lowPowerIn = 1'b0;
    wr('h0, 'h0314);                 // try to clear pause
    expect_reg('h0, 'h0315, "R7 pause bit write-once");
    lowPowerIn = 1'b1;
    ticks(10);
    expect_obs(OBS_WDR, 0, "R7 still frozen after ignored write");
    lowPowerIn = 1'b0;
    ticks(3);
    expect_obs(OBS_WDR, 0, "R2 no expiry at tick T");
    ticks(1);
    expect_obs(OBS_WDR, 1, "R2 expiry at tick T+1");

    // Segment D: masked reset, read-only status, cancelled power-down, soft reset
    do_reset();
    wr('h8, 'h0000);
    wr('h8, 'h0001);
    expect_reg('h8, 'h0000, "R9 cancel cannot be undone");
    wr('h0, 'h001C);                 // T=0, mask, run
    ticks(1);
    expect_obs(OBS_WDR, 0, "R10 masked reset request");
    expect_reg('h4, 'h0002, "R10 status still records timeout");
    wr('h4, 'h0000);
    expect_reg('h4, 'h0002, "R11 status write ignored");
    ticks(PDN_TICKS + 8);
    check_direct(pdnLowCount, 0, "R9 cancelled counter never pulses");

    expect_obs(OBS_SWR, 0, "R8 no soft reset yet");
    wr('h0, 'h0004);
    expect_obs(OBS_SWR, 1, "R8 soft reset requested");
    wr('h0, 'h0004);
    wr('h0, 'h0004);
    expect_obs(OBS_SWR, 1, "R8 request held after repeats");
    expect_reg('h0, 'h0014, "R8 control readback");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule